// File: doc/BRIEF.md
# Two-Group Secure Interrupt CPU Interface

This block is the per-core end of an interrupt controller. Each cycle a distributor presents the single best pending interrupt: an ID, an 8-bit priority and a group bit. The interface decides whether that interrupt may be signalled to the core. If it may, the interface raises either the normal interrupt line or the fast interrupt line, depending on the group and on the control settings. Group 0 is the secure, higher-priority class. Group 1 is the non-secure class, and it can only ever use the normal line.

Software reaches the interface through a small register port. Every access carries a security attribute. That attribute decides which of several things the access gets:

- which banked copy of the control and binary-point state it sees;
- whether it may claim the pending interrupt;
- whether it may retire an active interrupt.

A non-secure access sees a halved, shifted image of the secure priority space. A small stack of acknowledged interrupts provides the running priority. That stack, together with the binary-point grouping of priorities, governs preemption.

Top module: `grp_cpu_iface`

## Requirements
- R1: After reset:
  - both interrupt lines are low and all control bits are 0;
  - the priority mask reads 0;
  - the secure binary point reads 2 and the non-secure binary point reads 3;
  - the running priority reads 0xFF, and it reads 0xFF whenever no interrupt is active.
- R2: A deliverable interrupt asserts exactly one line.
  - It asserts the fast line when its group bit is 0 and control bit 3 (fast-route enable) is 1.
  - In every other case it asserts the normal line, so a group 1 interrupt never asserts the fast line.
- R3: The pending interrupt is deliverable only when all of the following hold:
  - the valid input is high;
  - the enable of its group is set (control bit 0 for group 0, bit 1 for group 1);
  - its priority is numerically below the priority mask;
  - the active stack is not full;
  - either the stack is empty, or its group priority is below the group priority of the running priority. Group priority is the priority with bits [bp:0] cleared. The binary point bp is the secure copy for group 0 and the non-secure copy for group 1.
- R4: Control register (address 0) is banked by security state.
  - A secure access reads and writes bits [3:0]: bit 0 group 0 enable, bit 1 group 1 enable, bit 2 secure-claim-of-group-1 enable, bit 3 fast-route enable.
  - A non-secure access sees only the group 1 enable, at bit 0, and its writes change nothing else.
- R5: Binary point is a 3-bit value.
  - An access to address 2 reaches the copy of its own security state.
  - A secure access to address 7 reaches the non-secure copy.
  - A non-secure access to address 7 reads 0 and its writes are ignored.
- R6: Reading address 3 (acknowledge) returns an ID according to these rules:
  - It returns 1023 when nothing is deliverable.
  - It returns 1023 when a non-secure access meets a group 0 interrupt.
  - It returns 1022 when a secure access meets a group 1 interrupt while control bit 2 is 0.
  - Otherwise it returns the pending ID.
  - A read that returns 1022 or 1023 has no side effect.
- R7: An acknowledge that returns a real ID does three things:
  - it pushes the interrupt onto the active stack;
  - the running priority then equals that interrupt's priority;
  - on the following cycle the claim pulse output is high for one cycle, carrying the ID.
- R8: Reading address 6 (highest pending) returns the same value an acknowledge would. It changes no state and produces no claim pulse.
- R9: A write to address 4 (end of interrupt) carrying the ID of the top stack entry pops that entry and produces a one-cycle retire pulse with the ID. The write is ignored in two cases:
  - when the ID does not match the top entry;
  - when the top entry is group 0 and the access is non-secure.
- R10: Non-secure reads of the priority mask (address 1) and the running priority (address 5) return (value×2) mod 256 when value bit 7 is 1, and 0 otherwise. Secure reads return the stored value.
- R11: A secure write to address 1 stores the mask as given. A non-secure write stores (data>>1)|0x80, and only when the stored mask already has bit 7 set; otherwise it is ignored.
- R12: The active stack holds STK_DEPTH entries. When it is full, acknowledge returns 1023 and neither line is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_valid | input | 1 | A pending interrupt is presented |
| pend_id | input | ID_W | ID of the pending interrupt |
| pend_prio | input | 8 | Priority of the pending interrupt (lower is more urgent) |
| pend_grp | input | 1 | Group of the pending interrupt (0 secure, 1 non-secure) |
| reg_req | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_sec | input | 1 | Security attribute of the access (1 secure) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the current address and attribute |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| ack_fire | output | 1 | One-cycle claim pulse after a successful acknowledge |
| ack_id | output | ID_W | ID claimed |
| eoi_fire | output | 1 | One-cycle retire pulse after an accepted end of interrupt |
| eoi_id | output | ID_W | ID retired |

## Verification
The assertions check the following on every cycle:
- the two lines are never high together, and a group 1 interrupt never drives the fast line;
- any asserted line has a priority below the mask;
- the stack depth stays within its bound and moves by exactly one on each claim or retire pulse;
- a non-secure claim is never of group 0, and a non-secure retire is never of a group 0 entry.

The bench scenarios are the only place the following are shown:
- the exact acknowledge codes 1022 and 1023;
- the banked register views and the alias;
- the shifted non-secure priority image;
- preemption through binary-point grouping;
- the full-stack refusal;
- the rejection of mismatched end-of-interrupt IDs.

These require known register contents and sequences. A near-exhaustive sweep compares both lines against an arithmetic model over enables, routing, mask and priority.

// File: rtl/gci_pkg.sv
package gci_pkg;

  typedef enum logic [2:0] {
    RA_CTRL     = 3'd0,
    RA_PMASK    = 3'd1,
    RA_BINPT    = 3'd2,
    RA_ACK      = 3'd3,
    RA_EOI      = 3'd4,
    RA_RUNPRI   = 3'd5,
    RA_HIPEND   = 3'd6,
    RA_BINPT_AL = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic fiq_en;   // bit 3
    logic ack_ctl;  // bit 2
    logic en_g1;    // bit 1
    logic en_g0;    // bit 0
  } ctrl_t;

  localparam int unsigned CODE_NONE   = 1023;
  localparam int unsigned CODE_G1_SEC = 1022;

  // Priority with bits [bp:0] cleared.
  function automatic logic [7:0] grp_prio(input logic [7:0] p, input logic [2:0] bp);
    logic [3:0] sh;
    logic [8:0] m;
    sh = {1'b0, bp} + 4'd1;
    m  = 9'h1FF << sh;
    return p & m[7:0];
  endfunction

  // Image of a secure priority value seen by a non-secure read.
  function automatic logic [7:0] ns_view(input logic [7:0] v);
    return v[7] ? {v[6:0], 1'b0} : 8'h00;
  endfunction

  // Stored value produced by a non-secure priority write.
  function automatic logic [7:0] ns_store(input logic [7:0] v);
    return {1'b1, v[7:1]};
  endfunction

endpackage

// File: rtl/gci_regbank.sv
module gci_regbank
  import gci_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        sec,
  input  reg_addr_e   addr,
  input  logic [7:0]  wdata,
  output ctrl_t       ctrl,
  output logic [7:0]  pmask,
  output logic [2:0]  bpr_s,
  output logic [2:0]  bpr_ns
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      pmask  <= 8'h00;
      bpr_s  <= 3'd2;
      bpr_ns <= 3'd3;
    end else if (wr_en) begin
      unique case (addr)
        RA_CTRL: begin
          if (sec) ctrl <= ctrl_t'(wdata[3:0]);
          else     ctrl.en_g1 <= wdata[0];
        end
        RA_PMASK: begin
          if (sec)           pmask <= wdata;
          else if (pmask[7]) pmask <= ns_store(wdata);
        end
        RA_BINPT: begin
          if (sec) bpr_s  <= wdata[2:0];
          else     bpr_ns <= wdata[2:0];
        end
        RA_BINPT_AL: begin
          if (sec) bpr_ns <= wdata[2:0];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gci_actstack.sv
module gci_actstack #(
  parameter  int DEPTH = 4,
  parameter  int ID_W  = 10,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ID_W-1:0]  push_id,
  input  logic [7:0]       push_prio,
  input  logic             push_grp,
  input  logic             pop,
  output logic [CNT_W-1:0] depth,
  output logic             empty,
  output logic             full,
  output logic [ID_W-1:0]  top_id,
  output logic [7:0]       top_prio,
  output logic             top_grp
);

  logic [ID_W-1:0] id_q   [DEPTH];
  logic [7:0]      prio_q [DEPTH];
  logic            grp_q  [DEPTH];
  logic [CNT_W-1:0] top_ix;

  assign empty  = (depth == '0);
  assign full   = (depth == CNT_W'(DEPTH));
  assign top_ix = depth - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        id_q[i]   <= '0;
        prio_q[i] <= 8'hFF;
        grp_q[i]  <= 1'b0;
      end
    end else if (push && !full) begin
      id_q[depth[IDX_W-1:0]]   <= push_id;
      prio_q[depth[IDX_W-1:0]] <= push_prio;
      grp_q[depth[IDX_W-1:0]]  <= push_grp;
      depth <= depth + CNT_W'(1);
    end else if (pop && !empty) begin
      depth <= depth - CNT_W'(1);
    end
  end

  assign top_id   = empty ? '0    : id_q[top_ix[IDX_W-1:0]];
  assign top_prio = empty ? 8'hFF : prio_q[top_ix[IDX_W-1:0]];
  assign top_grp  = empty ? 1'b0  : grp_q[top_ix[IDX_W-1:0]];

endmodule

// File: rtl/gci_select.sv
module gci_select
  import gci_pkg::*;
#(
  parameter int ID_W = 10
) (
  input  logic            pend_valid,
  input  logic [ID_W-1:0] pend_id,
  input  logic [7:0]      pend_prio,
  input  logic            pend_grp,
  input  ctrl_t           ctrl,
  input  logic [7:0]      pmask,
  input  logic [2:0]      bpr_s,
  input  logic [2:0]      bpr_ns,
  input  logic [7:0]      run_prio,
  input  logic            stk_empty,
  input  logic            stk_full,
  input  logic            sec,
  output logic            deliver,
  output logic            irq,
  output logic            fiq,
  output logic [ID_W-1:0] ack_code,
  output logic            ack_real
);

  logic [2:0] bp;
  logic       grp_en;
  logic       preempt;
  logic       fast;

  assign bp      = pend_grp ? bpr_ns : bpr_s;
  assign grp_en  = pend_grp ? ctrl.en_g1 : ctrl.en_g0;
  assign preempt = stk_empty || (grp_prio(pend_prio, bp) < grp_prio(run_prio, bp));
  assign deliver = pend_valid && grp_en && (pend_prio < pmask) && preempt && !stk_full;

  assign fast = !pend_grp && ctrl.fiq_en;
  assign fiq  = deliver && fast;
  assign irq  = deliver && !fast;

  always_comb begin
    ack_real = 1'b0;
    ack_code = ID_W'(CODE_NONE);
    if (deliver) begin
      if (!pend_grp) begin
        if (sec) begin
          ack_real = 1'b1;
          ack_code = pend_id;
        end
      end else if (!sec || ctrl.ack_ctl) begin
        ack_real = 1'b1;
        ack_code = pend_id;
      end else begin
        ack_code = ID_W'(CODE_G1_SEC);
      end
    end
  end

endmodule

// File: rtl/grp_cpu_iface.sv
module grp_cpu_iface
  import gci_pkg::*;
#(
  parameter  int ID_W      = 10,
  parameter  int DATA_W    = 16,
  parameter  int STK_DEPTH = 4,
  localparam int CNT_W     = $clog2(STK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_valid,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [7:0]        pend_prio,
  input  logic              pend_grp,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic              reg_sec,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              ack_fire,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_fire,
  output logic [ID_W-1:0]   eoi_id
);

  reg_addr_e        addr_e;
  ctrl_t            ctrl_q;
  logic [7:0]       pmask_q;
  logic [2:0]       bpr_s_q, bpr_ns_q;
  logic [CNT_W-1:0] stk_depth;
  logic             stk_empty, stk_full;
  logic [ID_W-1:0]  top_id;
  logic [7:0]       run_prio;
  logic             top_grp;
  logic             deliver, ack_real;
  logic [ID_W-1:0]  ack_code;
  logic             ack_take, eoi_take;
  logic             unused_wbits;

  assign addr_e       = reg_addr_e'(reg_addr);
  assign unused_wbits = ^reg_wdata[DATA_W-1:ID_W];

  gci_regbank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_req && reg_wr),
    .sec    (reg_sec),
    .addr   (addr_e),
    .wdata  (reg_wdata[7:0]),
    .ctrl   (ctrl_q),
    .pmask  (pmask_q),
    .bpr_s  (bpr_s_q),
    .bpr_ns (bpr_ns_q)
  );

  gci_select #(.ID_W(ID_W)) u_sel (
    .pend_valid (pend_valid),
    .pend_id    (pend_id),
    .pend_prio  (pend_prio),
    .pend_grp   (pend_grp),
    .ctrl       (ctrl_q),
    .pmask      (pmask_q),
    .bpr_s      (bpr_s_q),
    .bpr_ns     (bpr_ns_q),
    .run_prio   (run_prio),
    .stk_empty  (stk_empty),
    .stk_full   (stk_full),
    .sec        (reg_sec),
    .deliver    (deliver),
    .irq        (irq_o),
    .fiq        (fiq_o),
    .ack_code   (ack_code),
    .ack_real   (ack_real)
  );

  assign ack_take = reg_req && !reg_wr && (addr_e == RA_ACK) && ack_real;
  assign eoi_take = reg_req && reg_wr && (addr_e == RA_EOI) && !stk_empty
                    && (reg_wdata[ID_W-1:0] == top_id) && (top_grp || reg_sec);

  gci_actstack #(.DEPTH(STK_DEPTH), .ID_W(ID_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_take),
    .push_id   (pend_id),
    .push_prio (pend_prio),
    .push_grp  (pend_grp),
    .pop       (eoi_take),
    .depth     (stk_depth),
    .empty     (stk_empty),
    .full      (stk_full),
    .top_id    (top_id),
    .top_prio  (run_prio),
    .top_grp   (top_grp)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (addr_e)
      RA_CTRL:     reg_rdata = reg_sec ? DATA_W'(ctrl_q) : DATA_W'(ctrl_q.en_g1);
      RA_PMASK:    reg_rdata = DATA_W'(reg_sec ? pmask_q : ns_view(pmask_q));
      RA_BINPT:    reg_rdata = DATA_W'(reg_sec ? bpr_s_q : bpr_ns_q);
      RA_ACK:      reg_rdata = DATA_W'(ack_code);
      RA_EOI:      reg_rdata = '0;
      RA_RUNPRI:   reg_rdata = DATA_W'(reg_sec ? run_prio : ns_view(run_prio));
      RA_HIPEND:   reg_rdata = DATA_W'(ack_code);
      RA_BINPT_AL: reg_rdata = reg_sec ? DATA_W'(bpr_ns_q) : '0;
      default:     reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_fire <= 1'b0;
      ack_id   <= '0;
      eoi_fire <= 1'b0;
      eoi_id   <= '0;
    end else begin
      ack_fire <= ack_take;
      eoi_fire <= eoi_take;
      if (ack_take) ack_id <= pend_id;
      if (eoi_take) eoi_id <= top_id;
    end
  end

endmodule

// File: rtl/gci_chk.sv
module gci_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             pend_grp,
  input logic [7:0]       pend_prio,
  input logic             reg_sec,
  input logic [7:0]       pmask_q,
  input logic [CNT_W-1:0] stk_depth,
  input logic [7:0]       run_prio,
  input logic             top_grp,
  input logic             ack_fire,
  input logic             eoi_fire
);

  a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));

  a_r2_g1_not_fast: assert property (@(posedge clk) disable iff (!rst_n)
    pend_grp |-> !fiq_o);

  a_r3_under_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> (pend_prio < pmask_q));

  a_r1_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_depth == '0) |-> (run_prio == 8'hFF));

  a_r12_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= CNT_W'(DEPTH));

  a_r7_push_one: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |-> (stk_depth == $past(stk_depth) + CNT_W'(1)));

  a_r9_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |-> (stk_depth == $past(stk_depth) - CNT_W'(1)));

  a_r6_ns_claim_g1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !$past(reg_sec)) |-> $past(pend_grp));

  a_r9_ns_retire_g1: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !$past(reg_sec)) |-> $past(top_grp));

endmodule

bind grp_cpu_iface gci_chk #(.DEPTH(STK_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .pend_grp  (pend_grp),
  .pend_prio (pend_prio),
  .reg_sec   (reg_sec),
  .pmask_q   (pmask_q),
  .stk_depth (stk_depth),
  .run_prio  (run_prio),
  .top_grp   (top_grp),
  .ack_fire  (ack_fire),
  .eoi_fire  (eoi_fire)
);

// File: tb/sim_grp_cpu_iface.sv
`timescale 1ns/1ps
module sim_grp_cpu_iface;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pend_valid = 1'b0;
  logic [9:0]  pend_id = '0;
  logic [7:0]  pend_prio = 8'hFF;
  logic        pend_grp = 1'b0;
  logic        reg_req = 1'b0, reg_wr = 1'b0, reg_sec = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o, fiq_o, ack_fire, eoi_fire;
  logic [9:0]  ack_id, eoi_id;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  grp_cpu_iface u0 (
    .clk(clk), .rst_n(rst_n),
    .pend_valid(pend_valid), .pend_id(pend_id), .pend_prio(pend_prio), .pend_grp(pend_grp),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_sec(reg_sec), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o),
    .ack_fire(ack_fire), .ack_id(ack_id), .eoi_fire(eoi_fire), .eoi_id(eoi_id)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] a, input logic w, input logic s,
                     input logic [15:0] d, output logic [15:0] r);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = w; reg_sec = s; reg_addr = a; reg_wdata = d;
    #5;
    r = reg_rdata;
    @(posedge clk);
    #1;
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic s, input logic [15:0] d);
    logic [15:0] junk;
    acc(a, 1'b1, s, d, junk);
  endtask

  task automatic rd(input logic [2:0] a, input logic s, output logic [15:0] r);
    acc(a, 1'b0, s, 16'h0, r);
  endtask

  task automatic setp(input logic v, input logic [9:0] id, input logic [7:0] p, input logic g);
    @(negedge clk);
    pend_valid = v; pend_id = id; pend_prio = p; pend_grp = g;
    #2;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    #2;
    chk("R1 irq", irq_o, 0);
    chk("R1 fiq", fiq_o, 0);
    chk("R1 ack_fire", ack_fire, 0);
    rd(3'd0, 1, r); chk("R1 ctrl", r, 0);
    rd(3'd1, 1, r); chk("R1 pmask", r, 0);
    rd(3'd2, 1, r); chk("R1 bpr_s", r, 2);
    rd(3'd2, 0, r); chk("R1 bpr_ns", r, 3);
    rd(3'd5, 1, r); chk("R1 runpri", r, 8'hFF);

    // R4 control banking
    wr(3'd0, 1, 16'hF);
    rd(3'd0, 1, r); chk("R4 sec view", r, 4'hF);
    rd(3'd0, 0, r); chk("R4 ns view", r, 1);
    wr(3'd0, 0, 16'h0);
    rd(3'd0, 1, r); chk("R4 ns clears en_g1 only", r, 4'hD);
    wr(3'd0, 0, 16'h1);
    rd(3'd0, 1, r); chk("R4 ns sets en_g1", r, 4'hF);

    // R5 binary point banking and alias
    wr(3'd2, 1, 16'd5);
    wr(3'd2, 0, 16'd1);
    rd(3'd7, 1, r); chk("R5 alias reads ns copy", r, 1);
    wr(3'd7, 1, 16'd6);
    rd(3'd2, 0, r); chk("R5 alias writes ns copy", r, 6);
    wr(3'd7, 0, 16'd0);
    rd(3'd2, 0, r); chk("R5 ns alias write ignored", r, 6);
    rd(3'd7, 0, r); chk("R5 ns alias reads zero", r, 0);
    rd(3'd2, 1, r); chk("R5 sec copy kept", r, 5);
    wr(3'd2, 1, 16'd2);
    wr(3'd7, 1, 16'd3);

    // R10 / R11 priority mask views
    wr(3'd1, 1, 16'h40);
    rd(3'd1, 0, r); chk("R10 ns mask view low", r, 0);
    wr(3'd1, 0, 16'h10);
    rd(3'd1, 1, r); chk("R11 ns write blocked", r, 16'h40);
    wr(3'd1, 1, 16'hF0);
    rd(3'd1, 0, r); chk("R10 ns mask view", r, 16'hE0);
    wr(3'd1, 0, 16'h20);
    rd(3'd1, 1, r); chk("R11 ns write stored", r, 16'h90);
    rd(3'd1, 0, r); chk("R10 ns readback", r, 16'h20);

    // R2 / R3 sweep with empty stack
    for (int en = 0; en < 4; en++) begin
      for (int fe = 0; fe < 2; fe++) begin
        wr(3'd0, 1, 16'(en + fe * 8));
        for (int mi = 0; mi < 4; mi++) begin
          int m;
          m = (mi == 0) ? 0 : (mi == 1) ? 8'h40 : (mi == 2) ? 8'h80 : 8'hFF;
          wr(3'd1, 1, 16'(m));
          for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < 256; p += 5) begin
              bit sig, ef, ei;
              setp(1'b1, 10'd9, 8'(p), g[0]);
              sig = ((g == 0) ? en[0] : en[1]) && (p < m);
              ef  = sig && (g == 0) && (fe == 1);
              ei  = sig && !ef;
              chk("R2 R3 sweep lines", {irq_o, fiq_o}, {ei, ef});
            end
          end
        end
      end
    end
    setp(1'b0, 10'd9, 8'h00, 1'b0);
    chk("R3 no valid no line", {irq_o, fiq_o}, 0);

    // R6 / R8 acknowledge filtering
    wr(3'd0, 1, 16'h3);
    wr(3'd1, 1, 16'hFF);
    rd(3'd6, 1, r); chk("R8 nothing pending", r, 1023);
    setp(1'b1, 10'd33, 8'h40, 1'b0);
    rd(3'd6, 0, r); chk("R8 ns hipend g0", r, 1023);
    rd(3'd3, 0, r); chk("R6 ns ack g0", r, 1023);
    chk("R6 no claim", ack_fire, 0);
    rd(3'd5, 1, r); chk("R6 no push", r, 8'hFF);
    setp(1'b1, 10'd77, 8'h60, 1'b1);
    rd(3'd6, 1, r); chk("R8 sec hipend g1 no ackctl", r, 1022);
    rd(3'd3, 1, r); chk("R6 sec ack g1 no ackctl", r, 1022);
    chk("R6 1022 no claim", ack_fire, 0);
    wr(3'd0, 1, 16'h7);
    rd(3'd6, 1, r); chk("R8 sec hipend g1", r, 77);
    chk("R8 no claim", ack_fire, 0);
    rd(3'd5, 1, r); chk("R8 no push", r, 8'hFF);

    // R7 acknowledge side effects
    rd(3'd3, 1, r); chk("R7 ack id", r, 77);
    chk("R7 claim pulse", ack_fire, 1);
    chk("R7 claim id", ack_id, 77);
    rd(3'd5, 1, r); chk("R7 running prio", r, 8'h60);
    chk("R7 pulse one cycle", ack_fire, 0);
    rd(3'd5, 0, r); chk("R10 ns runpri low", r, 0);

    // R3 preemption by group priority
    setp(1'b1, 10'd40, 8'h68, 1'b1);
    chk("R3 same group prio no preempt", irq_o, 0);
    setp(1'b1, 10'd41, 8'h50, 1'b1);
    chk("R3 g1 preempts", irq_o, 1);
    setp(1'b1, 10'd42, 8'h5F, 1'b0);
    chk("R3 g0 preempts via bpr_s", irq_o, 1);

    // R12 fill the stack
    setp(1'b1, 10'd5, 8'h50, 1'b0);
    rd(3'd3, 1, r); chk("R12 push 5", r, 5);
    setp(1'b1, 10'd6, 8'h40, 1'b0);
    rd(3'd3, 1, r); chk("R12 push 6", r, 6);
    setp(1'b1, 10'd7, 8'h30, 1'b0);
    rd(3'd3, 1, r); chk("R12 push 7", r, 7);
    setp(1'b1, 10'd8, 8'h10, 1'b0);
    chk("R12 full no line", {irq_o, fiq_o}, 0);
    rd(3'd3, 1, r); chk("R12 full ack", r, 1023);
    rd(3'd5, 1, r); chk("R12 running unchanged", r, 8'h30);

    // R9 end of interrupt
    setp(1'b0, 10'd0, 8'hFF, 1'b0);
    wr(3'd4, 0, 16'd7);
    chk("R9 ns eoi g0 ignored", eoi_fire, 0);
    rd(3'd5, 1, r); chk("R9 ns eoi no pop", r, 8'h30);
    wr(3'd4, 1, 16'd6);
    chk("R9 wrong id ignored", eoi_fire, 0);
    wr(3'd4, 1, 16'd7);
    chk("R9 retire pulse", eoi_fire, 1);
    chk("R9 retire id", eoi_id, 7);
    rd(3'd5, 1, r); chk("R9 pop to 0x40", r, 8'h40);
    wr(3'd4, 1, 16'd6);
    wr(3'd4, 1, 16'd5);
    rd(3'd5, 1, r); chk("R9 pop to 0x60", r, 8'h60);
    wr(3'd4, 0, 16'd77);
    chk("R9 ns eoi g1 accepted", eoi_fire, 1);
    rd(3'd5, 1, r); chk("R1 empty runpri", r, 8'hFF);

    // R10 shifted running priority
    setp(1'b1, 10'd100, 8'hA0, 1'b1);
    rd(3'd3, 0, r); chk("R6 ns ack g1", r, 100);
    rd(3'd5, 1, r); chk("R10 sec runpri", r, 8'hA0);
    rd(3'd5, 0, r); chk("R10 ns runpri", r, 8'h40);
    wr(3'd4, 0, 16'd100);
    rd(3'd5, 1, r); chk("R9 final pop", r, 8'hFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule